// File: doc/BRIEF.md
# Auto-Incrementing Packet Buffer Pointer

This block forms the buffer memory address for host accesses through the data register into packet storage. A host-writable pointer register holds a byte offset within a packet and three control flags: an area select (receive or transmit), an auto-advance enable and a transfer direction. The upper part of the address is a packet number. In the receive area it is the head entry of the receive queue. In the transmit area it is a packet number register that the host writes.

Each data access presents its width on a size code. When auto-advance is on, the offset then moves forward by the number of bytes transferred. The offset wraps within the packet page. The memory arrays and the host bus protocol sit outside the block. The block only supplies the address, the direction flag and a readback of the pointer register.

Top module: `pbuf_ptr_top`

## Requirements
- R1: After a synchronous reset the pointer readback is 0x0000 and the packet number register is 0. With the area flag clear, the output address is therefore 0.
- R2: A low-lane write loads offset bits 7:0. A high-lane write loads offset bits 10:8 and the control flags: area at bit 15, auto-advance at bit 14, read direction at bit 13. Bits 12:11 always read back as 0. A lane that is not written keeps its bits.
- R3: The output address is the 6-bit packet number concatenated above the 11-bit offset: `{pkt, offset}`.
- R4: With the area flag set (1), the packet number is the receive queue head input. With it clear (0), it is the packet number register.
- R5: An access with auto-advance set adds to the offset after the access: 1 for size code 0 (byte), 2 for code 1 (word), 4 for code 2 (double word) and 0 for code 3.
- R6: The offset advance wraps modulo 2048.
- R7: With auto-advance clear, accesses leave the pointer unchanged.
- R8: The direction output equals pointer bit 13 at all times.
- R9: A pointer write in the same cycle as an access takes priority. The access uses the old pointer, no advance occurs, and the written value is used from the next access on.
- R10: A packet number register write is visible from the following cycle. An access in the same cycle uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_wr_lo | input | 1 | Write strobe for pointer low byte |
| ptr_wr_hi | input | 1 | Write strobe for pointer high byte |
| ptr_wr_data | input | 16 | Pointer write data |
| ptr_rd_data | output | 16 | Pointer register readback |
| pnr_wr | input | 1 | Packet number register write strobe |
| pnr_wr_data | input | 6 | Packet number write data |
| rxq_head | input | 6 | Packet number at the receive queue head |
| acc_valid | input | 1 | Data-register access this cycle |
| acc_size | input | 2 | Access width code (0 byte, 1 word, 2 dword, 3 none) |
| buf_addr | output | 17 | Buffer memory address |
| buf_rd | output | 1 | Transfer direction (1 = read) |

## Verification
The hardest case to reach from the ports is a pointer write that lands in the same cycle as an auto-advancing access. Close behind it is the offset stepping across the 2047-to-0 boundary with a multi-byte width. The bench drives a strobe collision on purpose, for both a pointer lane and the packet number register. It checks the address in the colliding cycle and the pointer after it. The sweep loads start offsets just below the wrap point and runs every size code from there, with both area settings and both auto-advance settings.

// File: rtl/pbuf_ptr_pkg.sv
package pbuf_ptr_pkg;

    localparam int REG_W       = 16;
    localparam int LANE_W      = 8;
    localparam int CTL_RCV_BIT = 15;
    localparam int CTL_AI_BIT  = 14;
    localparam int CTL_RD_BIT  = 13;
    localparam int STEP_W      = 3;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2,
        ACC_NONE  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic rcv;
        logic autoinc;
        logic rd_dir;
    } ptr_ctrl_t;

    function automatic logic [STEP_W-1:0] step_of(acc_size_e sz);
        case (sz)
            ACC_BYTE:  return 3'd1;
            ACC_WORD:  return 3'd2;
            ACC_DWORD: return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/pbuf_ptr_reg.sv
module pbuf_ptr_reg
    import pbuf_ptr_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 acc_valid,
    input  acc_size_e            acc_size,
    output logic [OFS_W-1:0]     ofs,
    output ptr_ctrl_t            ctrl,
    output logic [REG_W-1:0]     rd_word
);

    logic [STEP_W-1:0] step;
    logic [OFS_W-1:0]  step_ext;
    logic [OFS_W-1:0]  ofs_inc;
    logic [OFS_W-1:0]  ofs_base;
    logic [OFS_W-1:0]  ofs_d;
    logic              any_wr;

    assign step     = step_of(acc_size);
    assign step_ext = {{(OFS_W-STEP_W){1'b0}}, step};
    assign ofs_inc  = ofs + step_ext;
    assign any_wr   = wr_lo | wr_hi;

    always_comb begin
        ofs_base = ofs;
        if (!any_wr && acc_valid && ctrl.autoinc) begin
            ofs_base = ofs_inc;
        end
    end

    for (genvar i = 0; i < OFS_W; i++) begin : g_bit
        if (i < LANE_W) begin : g_lo
            assign ofs_d[i] = wr_lo ? wr_data[i] : ofs_base[i];
        end else begin : g_hi
            assign ofs_d[i] = wr_hi ? wr_data[i] : ofs_base[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs  <= '0;
            ctrl <= '0;
        end else begin
            ofs <= ofs_d;
            if (wr_hi) begin
                ctrl.rcv     <= wr_data[CTL_RCV_BIT];
                ctrl.autoinc <= wr_data[CTL_AI_BIT];
                ctrl.rd_dir  <= wr_data[CTL_RD_BIT];
            end
        end
    end

    always_comb begin
        rd_word              = '0;
        rd_word[OFS_W-1:0]   = ofs;
        rd_word[CTL_RCV_BIT] = ctrl.rcv;
        rd_word[CTL_AI_BIT]  = ctrl.autoinc;
        rd_word[CTL_RD_BIT]  = ctrl.rd_dir;
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    AST_AUTO_STEP: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && ctrl.autoinc && !wr_lo && !wr_hi)
        |=> ((ofs - $past(ofs)) == $past(step_ext))); // R5

    AST_NO_INC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !ctrl.autoinc && !wr_lo && !wr_hi) |=> $stable(ofs)); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && wr_hi) |=> (ofs == $past(wr_data[OFS_W-1:0]))); // R9

    AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (rd_word[CTL_RCV_BIT:CTL_RD_BIT] == $past(wr_data[CTL_RCV_BIT:CTL_RD_BIT]))); // R2

endmodule

// File: rtl/pbuf_pnr_reg.sv
module pbuf_pnr_reg #(
    parameter int PKT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [PKT_W-1:0] wr_data,
    output logic [PKT_W-1:0] pnr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pnr_q <= '0;
        end else if (wr) begin
            pnr_q <= wr_data;
        end
    end

    AST_PNR_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr |=> (pnr_q == $past(wr_data))); // R10

    AST_PNR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(pnr_q)); // R10

endmodule

// File: rtl/pbuf_addr_mux.sv
module pbuf_addr_mux
    import pbuf_ptr_pkg::*;
#(
    parameter int OFS_W = 11,
    parameter int PKT_W = 6
) (
    input  ptr_ctrl_t                ctrl,
    input  logic [OFS_W-1:0]         ofs,
    input  logic [PKT_W-1:0]         rxq_head,
    input  logic [PKT_W-1:0]         pnr_q,
    output logic [PKT_W+OFS_W-1:0]   addr,
    output logic                     rd_dir
);

    logic [PKT_W-1:0] pkt_sel;

    always_comb begin
        pkt_sel = ctrl.rcv ? rxq_head : pnr_q;
        addr    = {pkt_sel, ofs};
        rd_dir  = ctrl.rd_dir;
    end

endmodule

// File: rtl/pbuf_ptr_top.sv
module pbuf_ptr_top
    import pbuf_ptr_pkg::*;
#(
    parameter int OFS_W = 11,
    parameter int PKT_W = 6,
    localparam int ADDR_W = PKT_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_wr_lo,
    input  logic              ptr_wr_hi,
    input  logic [15:0]       ptr_wr_data,
    output logic [15:0]       ptr_rd_data,
    input  logic              pnr_wr,
    input  logic [PKT_W-1:0]  pnr_wr_data,
    input  logic [PKT_W-1:0]  rxq_head,
    input  logic              acc_valid,
    input  logic [1:0]        acc_size,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd
);

    logic [OFS_W-1:0] ofs;
    ptr_ctrl_t        ctrl;
    logic [PKT_W-1:0] pnr_q;

    pbuf_ptr_reg #(.OFS_W(OFS_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .wr_lo     (ptr_wr_lo),
        .wr_hi     (ptr_wr_hi),
        .wr_data   (ptr_wr_data),
        .acc_valid (acc_valid),
        .acc_size  (acc_size_e'(acc_size)),
        .ofs       (ofs),
        .ctrl      (ctrl),
        .rd_word   (ptr_rd_data)
    );

    pbuf_pnr_reg #(.PKT_W(PKT_W)) u_pnr (
        .clk     (clk),
        .rst     (rst),
        .wr      (pnr_wr),
        .wr_data (pnr_wr_data),
        .pnr_q   (pnr_q)
    );

    pbuf_addr_mux #(.OFS_W(OFS_W), .PKT_W(PKT_W)) u_mux (
        .ctrl     (ctrl),
        .ofs      (ofs),
        .rxq_head (rxq_head),
        .pnr_q    (pnr_q),
        .addr     (buf_addr),
        .rd_dir   (buf_rd)
    );

    AST_RX_SRC: assert property (@(posedge clk) disable iff (rst)
        ptr_rd_data[CTL_RCV_BIT] |-> (buf_addr[ADDR_W-1:OFS_W] == rxq_head)); // R4

    AST_TX_SRC: assert property (@(posedge clk) disable iff (rst)
        !ptr_rd_data[CTL_RCV_BIT] |-> (buf_addr[ADDR_W-1:OFS_W] == pnr_q)); // R4

    AST_ADDR_OFS: assert property (@(posedge clk) disable iff (rst)
        buf_addr[OFS_W-1:0] == ptr_rd_data[OFS_W-1:0]); // R3

endmodule

// File: tb/pbuf_ptr_top_test.sv
`timescale 1ns/1ps
module pbuf_ptr_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ptr_wr_lo = 1'b0;
    logic        ptr_wr_hi = 1'b0;
    logic [15:0] ptr_wr_data = '0;
    logic [15:0] ptr_rd_data;
    logic        pnr_wr = 1'b0;
    logic [5:0]  pnr_wr_data = '0;
    logic [5:0]  rxq_head = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [16:0] buf_addr;
    logic        buf_rd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_ofs = 0;
    int m_pnr = 0;
    bit m_rcv = 0, m_ai = 0, m_rd = 0;

    always #4 clk = ~clk;

    pbuf_ptr_top uut (
        .clk(clk), .rst(rst),
        .ptr_wr_lo(ptr_wr_lo), .ptr_wr_hi(ptr_wr_hi),
        .ptr_wr_data(ptr_wr_data), .ptr_rd_data(ptr_rd_data),
        .pnr_wr(pnr_wr), .pnr_wr_data(pnr_wr_data),
        .rxq_head(rxq_head),
        .acc_valid(acc_valid), .acc_size(acc_size),
        .buf_addr(buf_addr), .buf_rd(buf_rd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int step_for(input int sz);
        case (sz)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_addr();
        int pkt;
        pkt = m_rcv ? int'(rxq_head) : m_pnr;
        return (pkt << 11) | m_ofs;
    endfunction

    function automatic int exp_ptr();
        return (int'(m_rcv) << 15) | (int'(m_ai) << 14) | (int'(m_rd) << 13) | m_ofs;
    endfunction

    task automatic wr_ptr(input bit lo, input bit hi, input logic [15:0] d);
        @(negedge clk);
        ptr_wr_lo = lo; ptr_wr_hi = hi; ptr_wr_data = d;
        @(posedge clk); #1;
        ptr_wr_lo = 0; ptr_wr_hi = 0;
        if (lo) m_ofs = (m_ofs & 32'h700) | int'(d[7:0]);
        if (hi) begin
            m_ofs = (m_ofs & 32'h0FF) | (int'(d[10:8]) << 8);
            m_rcv = d[15]; m_ai = d[14]; m_rd = d[13];
        end
    endtask

    task automatic wr_pnr(input logic [5:0] v);
        @(negedge clk);
        pnr_wr = 1; pnr_wr_data = v;
        @(posedge clk); #1;
        pnr_wr = 0;
        m_pnr = int'(v);
    endtask

    task automatic do_acc(input int sz);
        @(negedge clk);
        acc_valid = 1; acc_size = 2'(sz);
        #1;
        chk(int'(buf_addr) == exp_addr(), "R3 R4 address", int'(buf_addr), exp_addr());
        chk(buf_rd == m_rd, "R8 direction", int'(buf_rd), int'(m_rd));
        @(posedge clk); #1;
        acc_valid = 0;
        if (m_ai) m_ofs = (m_ofs + step_for(sz)) % 2048;
    endtask

    task automatic chk_ptr(input string req);
        @(negedge clk); #1;
        chk(int'(ptr_rd_data) == exp_ptr(), req, int'(ptr_rd_data), exp_ptr());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state
        #1;
        chk(ptr_rd_data == 16'h0000, "R1 pointer reset", int'(ptr_rd_data), 0);
        chk(buf_addr == '0, "R1 address reset", int'(buf_addr), 0);
        rxq_head = 6'h2A; #1;
        chk(buf_addr == '0, "R4 transmit area ignores queue head", int'(buf_addr), 0);

        // Sweep: area, auto-advance, size code, start offset (incl. wrap region) - R5 R6 R7
        for (int rcv = 0; rcv < 2; rcv++) begin
            for (int ai = 0; ai < 2; ai++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int s = 0; s < 8; s++) begin
                        int start;
                        start = (s < 4) ? (s * 103 + 1) : (2048 - (8 - s));
                        rxq_head = 6'((s * 7 + sz * 3 + 1) & 63);
                        wr_pnr(6'((s * 11 + 5) & 63));
                        wr_ptr(1, 1, {1'(rcv), 1'(ai), 1'(s & 1), 2'b00, 11'(start)});
                        chk_ptr("R2 pointer load");
                        for (int k = 0; k < 3; k++) do_acc(sz);
                        if (ai == 0) chk_ptr("R7 hold without auto-advance");
                        else chk_ptr("R5 R6 advance and wrap");
                    end
                end
            end
        end

        // R2: lane writes and reserved bits
        wr_ptr(1, 1, 16'h0000);
        wr_ptr(1, 0, 16'hFFAB);
        chk_ptr("R2 low lane only");
        chk(ptr_rd_data == 16'h00AB, "R2 low lane value", int'(ptr_rd_data), 16'h00AB);
        wr_ptr(0, 1, 16'hFFFF);
        chk_ptr("R2 high lane and reserved bits");
        chk(ptr_rd_data == 16'hE7AB, "R2 reserved bits zero", int'(ptr_rd_data), 16'hE7AB);

        // R9: pointer write collides with an advancing access
        wr_pnr(6'd3);
        wr_ptr(1, 1, 16'h4100);
        @(negedge clk);
        acc_valid = 1; acc_size = 2'd1; ptr_wr_lo = 1; ptr_wr_data = 16'h0055;
        #1;
        chk(int'(buf_addr) == ((3 << 11) | 16'h100), "R9 access uses old pointer",
            int'(buf_addr), (3 << 11) | 16'h100);
        @(posedge clk); #1;
        acc_valid = 0; ptr_wr_lo = 0;
        #1;
        chk(ptr_rd_data == 16'h4155, "R9 write wins, no advance", int'(ptr_rd_data), 16'h4155);
        m_ofs = 16'h155; m_ai = 1; m_rcv = 0; m_rd = 0;
        do_acc(2);
        chk_ptr("R9 new value used on next access");

        // R10: packet number write collides with an access
        wr_ptr(1, 1, 16'h0010);
        @(negedge clk);
        acc_valid = 1; acc_size = 2'd0; pnr_wr = 1; pnr_wr_data = 6'd9;
        #1;
        chk(int'(buf_addr) == ((3 << 11) | 16'h010), "R10 same-cycle uses old number",
            int'(buf_addr), (3 << 11) | 16'h010);
        @(posedge clk); #1;
        acc_valid = 0; pnr_wr = 0;
        m_pnr = 9;
        #1;
        chk(int'(buf_addr) == ((9 << 11) | 16'h010), "R10 new number next cycle",
            int'(buf_addr), (9 << 11) | 16'h010);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule